// File: doc/BRIEF.md
# Memory Card Start-up and Capacity Probe

This block takes a memory card attached over a four-wire serial link (chip select, clock, data out, data in) from power-on to a ready state in SPI mode, and then reports how many 512-byte sectors it holds. After reset it runs on its own. It sends wake-up clocks with the card deselected, issues the reset command, and repeats the initialise command with a pause between tries until the card reports ready. It then reads the 16-byte card-specific data register and decodes its capacity fields into a sector count.

When it finishes, the block presents an enabled flag, a fixed sector size, the 32-bit sector count and an error code. While the sequence is still running, the error code reads busy. Every outcome ends with a deselect sequence that leaves the link idle. Sector reads and writes are handled by other logic once the enabled flag and a zero error code are seen.

Top module: `sd_card_init`

## Requirements
- R1: After reset, chip select and data out stay high for at least WAKE_CLOCKS serial clocks. With WAKE_CLOCKS = 256 this is exactly 264 rising clock edges: 256 wake clocks plus one byte before select. Only then does chip select go low, and it does so while the serial clock is low.
- R2: Bytes go out MSB first. Data out changes only while the serial clock is low, and data in is sampled on the rising edge. The first command frame is 0x40 0x00 0x00 0x00 0x00 0x95.
- R3: After each command frame, response bytes are read with data out held high, up to RESP_TRIES bytes, stopping at the first byte with bit 7 clear. If no such byte arrives, the last byte read (0xFF when the card is silent) is taken as the response.
- R4: If the reset command's response has any bit other than bit 0 set, the block ends with error code 1 (command error) and the enabled flag cleared, and no initialise command is sent.
- R5: The initialise frame is 0x41 0x00 0x00 0x00 0x00 0xFF. A pause of at least RETRY_WAIT system cycles comes before each try. Tries repeat until the response is 0x00. A reset response of exactly 0x00 skips the initialise step entirely.
- R6: If INIT_TRIES initialise tries (255 by default) all fail to return 0x00, the block ends with error code 1 and the enabled flag cleared.
- R7: The register-read frame is 0x49 0x00 0x00 0x00 0x00 0x01. Its response value is not checked. The block then reads bytes until it sees 0xFE, for at most TOKEN_TRIES bytes. If 0xFE never arrives, it ends with error code 2 and the enabled flag cleared. Otherwise it captures 16 data bytes (byte 0 is the first received) and then clocks 2 check bytes that are not used.
- R8: The size field is C = {byte6[1:0], byte7, byte8[7:6]}, the multiplier is M = {byte9[1:0], byte10[7]}, and the block-length field is L = byte5[3:0]. The sector count is (C+1) shifted left by L+M-7. When L+M is below 7, it is instead shifted right by 7-(L+M).
- R9: From reset until the outcome, the error code reads 3 (busy), the enabled flag reads 1 and the sector count reads 0. Once the outcome is shown, all three hold their values until the next reset.
- R10: On success the error code becomes 0, the enabled flag stays 1 and the decoded sector count is presented. The sector size output always reads 512.
- R11: After the outcome is shown, the block sends one byte of clocks with chip select low and data out high, then one byte with chip select high. It then leaves the serial clock low and chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; the sequence starts on release |
| miso_i | input | 1 | Serial data from the card |
| cs_o | output | 1 | Card chip select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the card |
| enabled_o | output | 1 | Card usable; cleared on any failure |
| sector_size_o | output | 16 | Sector size in bytes, constant 512 |
| sector_count_o | output | 32 | Decoded capacity in sectors |
| err_o | output | 3 | 0 ok, 1 command error, 2 token timeout, 3 busy |

## Verification
The bench drives a behavioural card that parses command frames and queues replies. It targets the retry limit: a card that never becomes ready must see exactly 255 initialise frames, so an off-by-one counter shows up as 254 or 256 frames. Each try must also follow a pause; a design that skips the pause fails the gap check. Other cases are a card that stays silent after the reset command (a design that never times out the response window hangs), a lost data token (a design that waits forever never leaves busy), and a reset response of 0x00 (a design that sends the initialise command anyway is caught by the frame count). Capacity cases cover a right shift, a large left shift and a middle case with junk in the unused bits, so a field taken from the wrong bit slice or a shift in the wrong direction gives a wrong count.

// File: rtl/card_init_pkg.sv
package card_init_pkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_CMD     = 3'd1,
    ERR_TIMEOUT = 3'd2,
    ERR_BUSY    = 3'd3
  } init_err_e;

  typedef enum logic [3:0] {
    S_WAKE, S_CMD, S_RESP, S_PAUSE, S_TOKEN,
    S_DATA, S_CRC, S_DESEL_A, S_DESEL_B, S_DONE
  } init_state_e;

  typedef enum logic [1:0] {CMD_RESET, CMD_INIT, CMD_CSD} card_cmd_e;

  localparam int CSD_BYTES = 16;
  typedef logic [7:0] csd_bytes_t [CSD_BYTES];

  localparam logic [7:0] DATA_TOKEN = 8'hFE;

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          active_q, sclk_q, done_q;
  logic [CW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q, rx_q;
  logic          tick;

  assign tick = (div_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= 8'hFF;
      rx_q     <= 8'hFF;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          sh_q     <= tx_i;
          bit_q    <= '0;
          div_q    <= '0;
          sclk_q   <= 1'b0;
        end
      end else if (tick) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          sh_q   <= {sh_q[6:0], 1'b1};
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
      end else begin
        div_q <= div_q + CW'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = active_q ? sh_q[7] : 1'b1;
  assign done_o = done_q;
  assign rx_o   = rx_q;

endmodule

// File: rtl/csd_capacity.sv
module csd_capacity
  import card_init_pkg::*;
(
  input  csd_bytes_t  csd_i,
  output logic [31:0] sectors_o
);
  logic [11:0] c_size;
  logic [2:0]  mult;
  logic [3:0]  blk_len;
  logic [4:0]  expo;
  logic [31:0] base;

  always_comb begin
    c_size  = {csd_i[6][1:0], csd_i[7], csd_i[8][7:6]};
    mult    = {csd_i[9][1:0], csd_i[10][7]};
    blk_len = csd_i[5][3:0];
    expo    = 5'(blk_len) + 5'(mult);
    base    = 32'(c_size) + 32'd1;
    if (expo >= 5'd7) sectors_o = base << (expo - 5'd7);
    else              sectors_o = base >> (5'd7 - expo);
  end

endmodule

// File: rtl/sd_card_init.sv
module sd_card_init
  import card_init_pkg::*;
#(
  parameter int HALF_DIV     = 4,
  parameter int WAKE_CLOCKS  = 256,
  parameter int RESP_TRIES   = 255,
  parameter int INIT_TRIES   = 255,
  parameter int RETRY_WAIT   = 390000,
  parameter int TOKEN_TRIES  = 65536,
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        miso_i,
  output logic        cs_o,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        enabled_o,
  output logic [15:0] sector_size_o,
  output logic [31:0] sector_count_o,
  output logic [2:0]  err_o
);
  localparam int WAKE_BYTES = WAKE_CLOCKS / 8 + 1;
  localparam int CNT_W  = $clog2(TOKEN_TRIES + RESP_TRIES + WAKE_BYTES + 32);
  localparam int TRY_W  = $clog2(INIT_TRIES + 1);
  localparam int WAIT_W = $clog2(RETRY_WAIT + 1);

  init_state_e       state_q;
  card_cmd_e         cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TRY_W-1:0]  try_q;
  logic [WAIT_W-1:0] wait_q;
  logic              go_q, cs_q, en_q;
  init_err_e         err_q;
  logic [31:0]       count_q;

  logic        eng_done;
  logic [7:0]  eng_rx, tx_byte, cmd_byte, crc_byte;
  logic        resp_last, cap_en;
  csd_bytes_t  csd_q;
  logic [31:0] dec_count;

  spi_byte_engine #(.HALF_DIV(HALF_DIV)) u_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(go_q),
    .tx_i   (tx_byte),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .done_o (eng_done),
    .rx_o   (eng_rx)
  );

  csd_capacity u_decode (
    .csd_i    (csd_q),
    .sectors_o(dec_count)
  );

  always_comb begin
    unique case (cmd_q)
      CMD_RESET: begin cmd_byte = 8'h40; crc_byte = 8'h95; end
      CMD_INIT:  begin cmd_byte = 8'h41; crc_byte = 8'hFF; end
      default:   begin cmd_byte = 8'h49; crc_byte = 8'h01; end
    endcase
    tx_byte = 8'hFF;
    if (state_q == S_CMD) begin
      if (cnt_q == '0)               tx_byte = cmd_byte;
      else if (cnt_q == CNT_W'(5))   tx_byte = crc_byte;
      else                           tx_byte = 8'h00;
    end
  end

  assign resp_last = !eng_rx[7] || (cnt_q == CNT_W'(RESP_TRIES - 1));
  assign cap_en    = eng_done && (state_q == S_DATA);

  for (genvar g = 0; g < CSD_BYTES; g++) begin : g_csd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          csd_q[g] <= 8'h00;
      else if (cap_en && cnt_q[3:0] == 4'(g)) csd_q[g] <= eng_rx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_WAKE;
      cmd_q   <= CMD_RESET;
      cnt_q   <= '0;
      try_q   <= '0;
      wait_q  <= '0;
      go_q    <= 1'b1;
      cs_q    <= 1'b1;
      en_q    <= 1'b1;
      err_q   <= ERR_BUSY;
      count_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (state_q == S_PAUSE) begin
        if (wait_q == WAIT_W'(RETRY_WAIT - 1)) begin
          wait_q  <= '0;
          state_q <= S_CMD;
          cmd_q   <= CMD_INIT;
          cnt_q   <= '0;
          go_q    <= 1'b1;
        end else begin
          wait_q <= wait_q + WAIT_W'(1);
        end
      end else if (eng_done) begin
        go_q <= 1'b1;
        unique case (state_q)
          S_WAKE: begin
            if (cnt_q == CNT_W'(WAKE_BYTES - 1)) begin
              cs_q    <= 1'b0;
              state_q <= S_CMD;
              cmd_q   <= CMD_RESET;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_CMD: begin
            if (cnt_q == CNT_W'(5)) begin
              state_q <= S_RESP;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_RESP: begin
            if (resp_last) begin
              cnt_q <= '0;
              unique case (cmd_q)
                CMD_RESET: begin
                  if (|(eng_rx & 8'hFE)) begin
                    en_q <= 1'b0; err_q <= ERR_CMD; state_q <= S_DESEL_A;
                  end else if (eng_rx == 8'h00) begin
                    state_q <= S_CMD; cmd_q <= CMD_CSD;
                  end else begin
                    state_q <= S_PAUSE; try_q <= '0; go_q <= 1'b0;
                  end
                end
                CMD_INIT: begin
                  if (eng_rx == 8'h00) begin
                    state_q <= S_CMD; cmd_q <= CMD_CSD;
                  end else if (try_q == TRY_W'(INIT_TRIES - 1)) begin
                    en_q <= 1'b0; err_q <= ERR_CMD; state_q <= S_DESEL_A;
                  end else begin
                    try_q <= try_q + TRY_W'(1); state_q <= S_PAUSE; go_q <= 1'b0;
                  end
                end
                default: state_q <= S_TOKEN;
              endcase
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_TOKEN: begin
            if (eng_rx == DATA_TOKEN) begin
              state_q <= S_DATA; cnt_q <= '0;
            end else if (cnt_q == CNT_W'(TOKEN_TRIES - 1)) begin
              en_q <= 1'b0; err_q <= ERR_TIMEOUT; state_q <= S_DESEL_A;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_DATA: begin
            if (cnt_q == CNT_W'(CSD_BYTES - 1)) begin
              state_q <= S_CRC; cnt_q <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_CRC: begin
            if (cnt_q == CNT_W'(1)) begin
              err_q   <= ERR_NONE;
              count_q <= dec_count;
              state_q <= S_DESEL_A;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_DESEL_A: begin
            cs_q    <= 1'b1;
            state_q <= S_DESEL_B;
          end
          default: begin
            state_q <= S_DONE;
            go_q    <= 1'b0;
          end
        endcase
      end
    end
  end

  assign cs_o           = cs_q;
  assign enabled_o      = en_q;
  assign err_o          = err_q;
  assign sector_count_o = count_q;
  assign sector_size_o  = 16'(SECTOR_BYTES);

endmodule

// File: rtl/sd_card_init_chk.sv
module sd_card_init_chk #(
  parameter int WAKE_CLOCKS = 256
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_o,
  input logic        sclk_o,
  input logic        mosi_o,
  input logic        enabled_o,
  input logic [31:0] sector_count_o,
  input logic [2:0]  err_o
);
  logic        seen_low_q, sclk_d;
  logic [31:0] wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_low_q <= 1'b0;
      sclk_d     <= 1'b0;
      wake_q     <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (!cs_o) seen_low_q <= 1'b1;
      else if (!seen_low_q && sclk_o && !sclk_d) wake_q <= wake_q + 32'd1;
    end
  end

  assert_wake_clocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_o) && !seen_low_q) |-> (wake_q >= 32'(WAKE_CLOCKS)));

  assert_select_clock_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> !sclk_o);

  assert_busy_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o == 3'd3) |-> (enabled_o && sector_count_o == 32'd0));

  assert_outcome_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 3'd3) |=> ($stable(err_o) && $stable(enabled_o) && $stable(sector_count_o)));

  assert_fail_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_o |-> (err_o == 3'd1 || err_o == 3'd2));

  assert_deselect_mosi_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> mosi_o);

endmodule

bind sd_card_init sd_card_init_chk #(.WAKE_CLOCKS(WAKE_CLOCKS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_o          (cs_o),
  .sclk_o        (sclk_o),
  .mosi_o        (mosi_o),
  .enabled_o     (enabled_o),
  .sector_count_o(sector_count_o),
  .err_o         (err_o)
);

// File: tb/sd_card_init_bench.sv
`timescale 1ns/1ps
module sd_card_init_bench;
  localparam int RETRY_WAIT  = 200;
  localparam int TOKEN_TRIES = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_o, sclk_o, mosi_o, enabled_o, miso;
  logic [15:0] sector_size_o;
  logic [31:0] sector_count_o;
  logic [2:0]  err_o;

  always #2.5 clk = ~clk;

  sd_card_init #(.HALF_DIV(1), .RETRY_WAIT(RETRY_WAIT), .TOKEN_TRIES(TOKEN_TRIES)) u_sd_card_init (
    .clk_i(clk), .rst_ni(rst_n), .miso_i(miso), .cs_o(cs_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .enabled_o(enabled_o), .sector_size_o(sector_size_o),
    .sector_count_o(sector_count_o), .err_o(err_o));

  int errors = 0, checks = 0, cyc = 0;

  // card model state and scenario settings
  logic [7:0] rsp_q[$];
  logic [7:0] out_sh = 8'hFF, in_sh = 8'hFF;
  logic [7:0] frame[6];
  logic [7:0] csd_img[16];
  int  bitc, fpos, n_cmd0, n_cmd1, n_cmd9, last_frame_cyc;
  int  wake_edges, desel_low, desel_high, init_busy;
  bit  load_next, in_frame, seen_low, wake_mosi_bad, desel_mosi_bad, outcome_seen;
  bit  mute0, drop_token, mon_en;
  logic [7:0] cmd0_resp;
  logic [2:0] exp_err;
  bit         exp_en;
  logic [31:0] exp_sec;

  assign miso = out_sh[7];

  task automatic check(string req, bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic handle_frame();
    logic [47:0] f;
    f = {frame[0], frame[1], frame[2], frame[3], frame[4], frame[5]};
    case (frame[0] & 8'h3F)
      8'd0: begin
        n_cmd0++;
        check("R2", f == 48'h40_0000_0000_95, "reset frame", f, 48'h40_0000_0000_95);
        if (!mute0) begin rsp_q.push_back(8'hFF); rsp_q.push_back(cmd0_resp); end
      end
      8'd1: begin
        n_cmd1++;
        check("R5", f == 48'h41_0000_0000_FF, "init frame", f, 48'h41_0000_0000_FF);
        check("R5", (cyc - last_frame_cyc) > RETRY_WAIT, "retry gap", cyc - last_frame_cyc, RETRY_WAIT);
        rsp_q.push_back(8'hFF);
        rsp_q.push_back((init_busy < 0 || n_cmd1 <= init_busy) ? 8'h01 : 8'h00);
      end
      8'd9: begin
        n_cmd9++;
        check("R7", f == 48'h49_0000_0000_01, "csd frame", f, 48'h49_0000_0000_01);
        rsp_q.push_back(8'hFF); rsp_q.push_back(8'h00); rsp_q.push_back(8'hFF);
        if (!drop_token) begin
          rsp_q.push_back(8'hFE);
          for (int i = 0; i < 16; i++) rsp_q.push_back(csd_img[i]);
          rsp_q.push_back(8'h12); rsp_q.push_back(8'h34);
        end
      end
      default: ;
    endcase
    last_frame_cyc = cyc;
  endtask

  task automatic take_byte(logic [7:0] b);
    if (!in_frame) begin
      if (b[7:6] == 2'b01) begin in_frame = 1; frame[0] = b; fpos = 1; end
    end else begin
      frame[fpos] = b;
      fpos++;
      if (fpos == 6) begin in_frame = 0; handle_frame(); end
    end
  endtask

  always @(posedge sclk_o) begin
    if (cs_o) begin
      bitc = 0;
      if (!seen_low) begin wake_edges++; if (!mosi_o) wake_mosi_bad = 1; end
      if (outcome_seen) desel_high++;
    end else begin
      seen_low = 1;
      if (outcome_seen) begin desel_low++; if (!mosi_o) desel_mosi_bad = 1; end
      in_sh = {in_sh[6:0], mosi_o};
      bitc++;
      if (bitc == 8) begin bitc = 0; load_next = 1; take_byte(in_sh); end
    end
  end

  always @(negedge sclk_o) begin
    if (load_next) begin
      load_next = 0;
      out_sh = (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'hFF;
    end else out_sh = {out_sh[6:0], 1'b1};
  end

  // per-clock reference comparison and watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      finish_up();
    end
    if (mon_en) begin
      check("R10", sector_size_o == 16'd512, "sector size", sector_size_o, 512);
      if (err_o == 3'd3) begin
        check("R9", enabled_o && sector_count_o == 0, "busy outputs", {enabled_o, sector_count_o}, 64'h1_0000_0000);
      end else begin
        outcome_seen = 1;
        check("R9", err_o == exp_err, "err code", err_o, exp_err);
        check("R10", enabled_o == exp_en, "enabled", enabled_o, exp_en);
        check("R8", sector_count_o == exp_sec, "sector count", sector_count_o, exp_sec);
      end
    end
  end

  function automatic void set_csd(int bl, int mt, int cs);
    for (int i = 0; i < 16; i++) csd_img[i] = 8'(8'h5A ^ (i * 37));
    csd_img[5]  = {csd_img[5][7:4], 4'(bl)};
    csd_img[6]  = {6'h3D, 2'(cs >> 10)};
    csd_img[7]  = 8'(cs >> 2);
    csd_img[8]  = {2'(cs), 6'h15};
    csd_img[9]  = {6'h0B, 2'(mt >> 1)};
    csd_img[10] = {1'(mt), 7'h13};
  endfunction

  function automatic logic [31:0] ref_count(int bl, int mt, int cs);
    int e = bl + mt - 7;
    longint b = cs + 1;
    return (e >= 0) ? 32'(b << e) : 32'(b >> (-e));
  endfunction

  task automatic run_case(string name, logic [2:0] e_err, bit e_en, logic [31:0] e_sec,
                          int e_cmd1, int e_cmd9);
    rst_n = 1'b0;
    rsp_q.delete();
    out_sh = 8'hFF; bitc = 0; load_next = 0; in_frame = 0; fpos = 0;
    n_cmd0 = 0; n_cmd1 = 0; n_cmd9 = 0; wake_edges = 0; desel_low = 0; desel_high = 0;
    seen_low = 0; wake_mosi_bad = 0; desel_mosi_bad = 0; outcome_seen = 0;
    exp_err = e_err; exp_en = e_en; exp_sec = e_sec;
    repeat (3) @(negedge clk);
    check("R9", cs_o && !sclk_o && err_o == 3'd3 && enabled_o && sector_count_o == 0,
          "reset state", {cs_o, sclk_o, err_o}, 5'b10011);
    last_frame_cyc = cyc;
    mon_en = 1;
    rst_n = 1'b1;
    while (err_o == 3'd3) @(negedge clk);
    repeat (80) @(negedge clk);
    mon_en = 0;
    $display("case %s done", name);
    check("R1", wake_edges == 264, "wake edges", wake_edges, 264);
    check("R1", !wake_mosi_bad, "mosi high in wake", wake_mosi_bad, 0);
    check("R2", n_cmd0 == 1, "reset frames", n_cmd0, 1);
    check("R6", n_cmd1 == e_cmd1, "init frames", n_cmd1, e_cmd1);
    check("R7", n_cmd9 == e_cmd9, "csd frames", n_cmd9, e_cmd9);
    check("R11", desel_low == 8 && !desel_mosi_bad, "deselect low byte", desel_low, 8);
    check("R11", desel_high == 8, "deselect high byte", desel_high, 8);
    check("R11", cs_o && !sclk_o, "idle link", {cs_o, sclk_o}, 2);
  endtask

  initial begin
    mon_en = 0; mute0 = 0; drop_token = 0; cmd0_resp = 8'h01; init_busy = 3;
    // R10 R8: normal card, three busy tries, left shift by 8
    set_csd(10, 5, 12'hE5B);
    run_case("normal", 3'd0, 1, ref_count(10, 5, 12'hE5B), 4, 1);
    // R4: illegal-command bit in reset response
    cmd0_resp = 8'h05;
    run_case("cmd0_err", 3'd1, 0, 0, 0, 0);
    // R3: silent card, response window expires with 0xFF
    cmd0_resp = 8'h01; mute0 = 1;
    run_case("silent", 3'd1, 0, 0, 0, 0);
    // R6: card never ready
    mute0 = 0; init_busy = -1;
    run_case("never_ready", 3'd1, 0, 0, 255, 0);
    // R7: data token never arrives
    init_busy = 0; drop_token = 1;
    run_case("no_token", 3'd2, 0, 0, 1, 1);
    // R5 R8: ready at reset, right shift case
    drop_token = 0; cmd0_resp = 8'h00;
    set_csd(2, 1, 12'h0FF);
    run_case("right_shift", 3'd0, 1, ref_count(2, 1, 12'h0FF), 0, 1);
    // R8: largest fields
    set_csd(15, 7, 12'hFFF);
    run_case("max_fields", 3'd0, 1, ref_count(15, 7, 12'hFFF), 0, 1);
    finish_up();
  end

endmodule